// File: doc/BRIEF.md
# EEPROM Page Write Sequencer

This block sits between the serial command decoder of a byte-wide serial EEPROM and its storage array. When a write command and its start address have been decoded, it opens a transaction. It keeps the upper address bits fixed and steps only the in-page offset. Each incoming data byte goes into a page buffer slot, unless the protection logic reports that the current address is locked. When chip select rises exactly on a byte boundary, and the write latch was set at the start, the buffered bytes are committed to the array. The buffer is drained one byte per clock in ascending offset order, inside a self-timed busy window.

The busy window lasts a fixed number of clock cycles, set by a parameter. While it runs, the block ignores new transactions. When it ends, the block pulses a clear request to the write-enable latch. A status view is also produced: all ones while busy, and the protection fields, the write latch and a zero ready bit when idle.

Top module: `pws_page_writer`

## Requirements
- R1: After reset, `busy`, `arr_we` and `wel_clr` are low, and `sr_out` shows the idle status.
- R2: `cur_addr` starts at `start_addr`. Each accepted byte advances only the low log2(PAGE) offset bits, modulo PAGE, and the page bits stay fixed. When more than PAGE bytes are sent, the later bytes overwrite the earlier ones at the same offset, so the last value wins.
- R3: A commit happens only when `cs_rise` arrives with `cs_aligned` high and at least one byte received. In every other case the transaction is discarded: no array write and no busy.
- R4: `wel` is sampled with `txn_start`. If it was low, the whole transaction is dropped at `cs_rise`, with no writes, no busy and no `wel_clr`.
- R5: Only offsets that received a byte are written to the array. All other locations are left untouched.
- R6: A byte presented while `addr_ok` is low is dropped on its own. The other bytes of the page are still written.
- R7: `busy` goes high in the cycle after the committing `cs_rise` and stays high for exactly BUSY_CYCLES cycles.
- R8: `wel_clr` is a one-cycle pulse in the first cycle after `busy` falls, and only after a committed write.
- R9: While `busy` is high, `txn_start`, `byte_vld` and `cs_rise` have no effect.
- R10: `sr_out` reads 8'hFF while busy. When idle it reads {prot_cfg[2], 3'b000, prot_cfg[1:0], wel, 1'b0}.
- R11: Array writes occur only while busy, at most one per cycle, in ascending offset order within the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | Write command and address decoded |
| start_addr | input | ADDR_W | First byte address of the transaction |
| byte_vld | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | Chip select rising event |
| cs_aligned | input | 1 | Serial bit counter is at a byte boundary |
| wel | input | 1 | Write-enable latch state |
| addr_ok | input | 1 | Protection logic allows writing `cur_addr` |
| prot_cfg | input | 3 | {pin-lock enable, block level[1:0]} for status |
| cur_addr | output | ADDR_W | Address that the next byte will occupy |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Internal write cycle in progress |
| wel_clr | output | 1 | Clear request for the write-enable latch |
| sr_out | output | 8 | Status byte view |

## Verification
The bench sweeps every start offset of a small page against byte counts of one, a few, exactly a page and more than a page. A design that stepped the page bits would write into the neighbouring page, and one that did not wrap would lose the overwrite. It also sends a transaction with an unaligned chip-select rise, one without the write latch, and one with no data bytes; a design that did not discard these would start a busy window or touch the array. A page that straddles a protection limit shows whether locked bytes are dropped one by one, rather than the whole page being dropped. A burst of commands during busy shows whether the busy window can be extended or restarted, and whether it lets in stray writes.

// File: rtl/pws_pkg.sv
package pws_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_COMMIT,
    ST_HOLD
  } pws_state_e;

  // Offset step that stays inside a page of the given depth.
  function automatic int unsigned wrap_inc(int unsigned off, int unsigned depth);
    if (off + 1 >= depth) return 0;
    return off + 1;
  endfunction

  // Status byte: all ones during the internal cycle.
  function automatic logic [7:0] status_view(logic [2:0] prot, logic wl, logic bsy);
    if (bsy) return 8'hFF;
    return {prot[2], 3'b000, prot[1:0], wl, 1'b0};
  endfunction

endpackage

// File: rtl/pws_page_buf.sv
module pws_page_buf #(
  parameter int PAGE = 64,
  parameter int DW   = 8,
  localparam int OFF_W = (PAGE > 1) ? $clog2(PAGE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [OFF_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid
);

  logic [DW-1:0]   slot_q [PAGE];
  logic [PAGE-1:0] vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < PAGE; i++) slot_q[i] <= '0;
    end else if (clr) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx]  <= 1'b1;
      slot_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data  = slot_q[rd_idx];
  assign rd_valid = vld_q[rd_idx];

  // R5: a cleared buffer holds no valid slot in the next cycle
  a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld_q == '0));

endmodule

// File: rtl/pws_busy_timer.sv
module pws_busy_timer #(
  parameter int CYCLES = 1000,
  localparam int CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign done = busy_q && (cnt_q == CNT_W'(CYCLES - 1));
  assign busy = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q && start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (done) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R7: the counter never passes the configured window
  a_r7_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CNT_W'(CYCLES)));

  // R9: a start during the window does not restart the count
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done && start) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/pws_page_writer.sv
module pws_page_writer
  import pws_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int PAGE        = 64,
  parameter int BUSY_CYCLES = 1000,
  localparam int OFF_W  = (PAGE > 1) ? $clog2(PAGE) : 1,
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              cs_rise,
  input  logic              cs_aligned,
  input  logic              wel,
  input  logic              addr_ok,
  input  logic [2:0]        prot_cfg,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  output logic              busy,
  output logic              wel_clr,
  output logic [7:0]        sr_out
);

  pws_state_e        state_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W-1:0]  idx_q;
  logic              armed_q;
  logic              got_q;
  logic              clr_q;

  // named internal events
  logic open_txn, take_byte, store_byte, commit_go, discard_txn, last_slot;
  logic tmr_busy, tmr_done;
  logic [7:0] buf_data;
  logic       buf_valid;

  assign open_txn    = (state_q == ST_IDLE) && txn_start;
  assign take_byte   = (state_q == ST_COLLECT) && byte_vld && !cs_rise;
  assign store_byte  = take_byte && addr_ok;
  assign commit_go   = (state_q == ST_COLLECT) && cs_rise && cs_aligned && armed_q && got_q;
  assign discard_txn = (state_q == ST_COLLECT) && cs_rise && !commit_go;
  assign last_slot   = (idx_q == OFF_W'(PAGE - 1));

  pws_page_buf #(.PAGE(PAGE), .DW(8)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (open_txn || discard_txn),
    .wr_en    (store_byte),
    .wr_idx   (off_q),
    .wr_data  (byte_data),
    .rd_idx   (idx_q),
    .rd_data  (buf_data),
    .rd_valid (buf_valid)
  );

  pws_busy_timer #(.CYCLES(BUSY_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (commit_go),
    .busy  (tmr_busy),
    .done  (tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      off_q   <= '0;
      idx_q   <= '0;
      armed_q <= 1'b0;
      got_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      clr_q <= tmr_done;
      unique case (state_q)
        ST_IDLE: begin
          if (txn_start) begin
            state_q <= ST_COLLECT;
            page_q  <= start_addr[ADDR_W-1:OFF_W];
            off_q   <= start_addr[OFF_W-1:0];
            armed_q <= wel;
            got_q   <= 1'b0;
          end
        end
        ST_COLLECT: begin
          if (commit_go) begin
            state_q <= ST_COMMIT;
            idx_q   <= '0;
          end else if (discard_txn) begin
            state_q <= ST_IDLE;
          end else if (take_byte) begin
            off_q <= OFF_W'(wrap_inc(int'(off_q), PAGE));
            got_q <= 1'b1;
          end
        end
        ST_COMMIT: begin
          if (tmr_done)       state_q <= ST_IDLE;
          else if (last_slot) state_q <= ST_HOLD;
          else                idx_q   <= idx_q + 1'b1;
        end
        ST_HOLD: begin
          if (tmr_done) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cur_addr  = {page_q, off_q};
  assign arr_we    = (state_q == ST_COMMIT) && buf_valid;
  assign arr_addr  = {page_q, idx_q};
  assign arr_wdata = buf_data;
  assign busy      = tmr_busy;
  assign wel_clr   = clr_q;
  assign sr_out    = status_view(prot_cfg, wel, tmr_busy);

  // R2: a byte never moves the page bits
  a_r2_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    take_byte |=> (cur_addr[ADDR_W-1:OFF_W] == $past(cur_addr[ADDR_W-1:OFF_W])));

  // R3: an unaligned chip-select rise never starts a cycle
  a_r3_unaligned_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_COLLECT) && cs_rise && !cs_aligned) |=> !busy);

  // R4: a transaction opened without the latch never starts a cycle
  a_r4_unarmed_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_COLLECT) && cs_rise && !armed_q) |=> !busy);

  // R7: a commit raises busy in the next cycle
  a_r7_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |=> busy);

  // R8: clear pulse comes right as busy falls and lasts one cycle
  a_r8_clr_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> (!busy && $past(busy)));
  a_r8_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wel_clr);

  // R9: a start during busy leaves the page register alone
  a_r9_page_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && txn_start) |=> $stable(page_q));

  // R11: array writes only inside the busy window
  a_r11_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

endmodule

// File: tb/tb_pws_page_writer.sv
module tb_pws_page_writer;

  localparam int ADDR_W = 6;
  localparam int PAGE   = 8;
  localparam int BUSY   = 24;
  localparam int MEMN   = 1 << ADDR_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              txn_start, byte_vld, cs_rise, cs_aligned, wel, addr_ok;
  logic [ADDR_W-1:0] start_addr;
  logic [7:0]        byte_data;
  logic [2:0]        prot_cfg;
  logic [ADDR_W-1:0] cur_addr, arr_addr;
  logic              arr_we, busy, wel_clr;
  logic [7:0]        arr_wdata, sr_out;

  int prot_lim = MEMN;
  assign addr_ok = (int'(cur_addr) < prot_lim);

  pws_page_writer #(.ADDR_W(ADDR_W), .PAGE(PAGE), .BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .start_addr(start_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
    .cs_aligned(cs_aligned), .wel(wel), .addr_ok(addr_ok), .prot_cfg(prot_cfg),
    .cur_addr(cur_addr), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .busy(busy), .wel_clr(wel_clr), .sr_out(sr_out)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] cap_mem [MEMN];
  logic [7:0] exp_mem [MEMN];
  int we_cnt = 0;
  int clr_cnt = 0;
  int last_we_addr = -1;
  int order_bad = 0;

  always @(negedge clk) begin
    if (arr_we) begin
      if (int'(arr_addr) <= last_we_addr) order_bad = order_bad + 1;
      last_we_addr = int'(arr_addr);
      cap_mem[arr_addr] = arr_wdata;
      we_cnt = we_cnt + 1;
    end
    if (wel_clr) clr_cnt = clr_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] idle_sr(logic [2:0] p, logic w);
    return {p[2], 3'b000, p[1], p[0], w, 1'b0};
  endfunction

  task automatic run_txn(input int pg, input int off, input int n, input bit aligned,
                         input bit wel_v, input int plim, input bit inject, input int salt);
    bit commit;
    int exp_we, bcnt, we0, clr0, mism;
    bit hit [PAGE];
    for (int k = 0; k < PAGE; k++) hit[k] = 0;
    prot_lim = plim;
    we0 = we_cnt;
    clr0 = clr_cnt;
    last_we_addr = -1;
    commit = aligned && wel_v && (n > 0);
    @(negedge clk);
    txn_start = 1'b1;
    start_addr = ADDR_W'(pg * PAGE + off);
    wel = wel_v;
    @(negedge clk);
    txn_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      int o, a;
      logic [7:0] d;
      o = (off + i) % PAGE;
      a = pg * PAGE + o;
      d = 8'((pg * 37 + i * 11 + off * 5 + salt) & 255);
      chk(int'(cur_addr) == a, "R2 cur_addr", int'(cur_addr), a);
      byte_vld = 1'b1;
      byte_data = d;
      if (commit && a < plim) begin
        exp_mem[a] = d;
        hit[o] = 1;
      end
      @(negedge clk);
    end
    byte_vld = 1'b0;
    cs_rise = 1'b1;
    cs_aligned = aligned;
    @(negedge clk);
    cs_rise = 1'b0;
    cs_aligned = 1'b0;
    exp_we = 0;
    for (int k = 0; k < PAGE; k++) if (hit[k]) exp_we++;
    bcnt = 0;
    while (busy && bcnt < 1000) begin
      bcnt++;
      if (inject && bcnt == 3) begin
        txn_start = 1'b1; start_addr = '0; byte_vld = 1'b1; byte_data = 8'h5A;
        cs_rise = 1'b1; cs_aligned = 1'b1; wel = 1'b1;
      end
      if (bcnt == 4) begin
        txn_start = 1'b0; byte_vld = 1'b0; cs_rise = 1'b0; cs_aligned = 1'b0;
      end
      if (bcnt == 5) chk(sr_out == 8'hFF, "R10 busy status", int'(sr_out), 255);
      @(negedge clk);
    end
    txn_start = 1'b0; byte_vld = 1'b0; cs_rise = 1'b0; cs_aligned = 1'b0;
    wel = wel_v;
    repeat (2) @(negedge clk);
    chk(bcnt == (commit ? BUSY : 0), "R7/R3/R4/R9 busy length", bcnt, commit ? BUSY : 0);
    chk((we_cnt - we0) == exp_we, "R5/R6/R11 write count", we_cnt - we0, exp_we);
    chk((clr_cnt - clr0) == int'(commit), "R8 wel_clr pulses", clr_cnt - clr0, int'(commit));
    mism = 0;
    for (int k = 0; k < MEMN; k++) if (cap_mem[k] !== exp_mem[k]) mism++;
    chk(mism == 0, "R2/R5/R6 array contents", mism, 0);
    chk(order_bad == 0, "R11 ascending order", order_bad, 0);
    prot_lim = MEMN;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int counts [4];
    counts = '{1, 3, 8, 11};
    for (int k = 0; k < MEMN; k++) begin cap_mem[k] = '0; exp_mem[k] = '0; end
    rst_n = 1'b0; txn_start = 0; byte_vld = 0; cs_rise = 0; cs_aligned = 0;
    wel = 0; start_addr = '0; byte_data = '0; prot_cfg = 3'b101;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(arr_we == 1'b0, "R1 arr_we", int'(arr_we), 0);
    chk(wel_clr == 1'b0, "R1 wel_clr", int'(wel_clr), 0);
    chk(sr_out == idle_sr(prot_cfg, wel), "R1 status", int'(sr_out), int'(idle_sr(prot_cfg, wel)));
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R5 R7 R8 R11: sweep of start offset and byte count, incl. wrap
    for (int off = 0; off < PAGE; off++)
      for (int s = 0; s < 4; s++)
        run_txn((off + s) % (MEMN / PAGE), off, counts[s], 1'b1, 1'b1, MEMN, 1'b0, off * 4 + s);

    // R6: page straddles a protection limit
    run_txn(5, 2, 6, 1'b1, 1'b1, 5 * PAGE + 5, 1'b0, 90);
    run_txn(6, 6, 10, 1'b1, 1'b1, 6 * PAGE + 3, 1'b0, 91);
    // R3: unaligned rise and empty transaction
    run_txn(2, 1, 4, 1'b0, 1'b1, MEMN, 1'b0, 92);
    run_txn(3, 0, 0, 1'b1, 1'b1, MEMN, 1'b0, 93);
    // R4: latch not set
    run_txn(4, 3, 5, 1'b1, 1'b0, MEMN, 1'b0, 94);
    // R9: commands during busy
    run_txn(7, 4, 3, 1'b1, 1'b1, MEMN, 1'b1, 95);

    // R10: idle status over all inputs
    for (int v = 0; v < 16; v++) begin
      prot_cfg = 3'(v & 7);
      wel = v[3];
      #1;
      chk(sr_out == idle_sr(prot_cfg, wel), "R10 idle status", int'(sr_out),
          int'(idle_sr(prot_cfg, wel)));
      @(negedge clk);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule